// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet port. It collects the first six bytes of each frame, which hold the 48-bit destination address. It then decides once per frame whether the frame is kept or discarded. The decision works from the class of the address (broadcast, multicast or unicast) and a few configuration inputs. These are a station address, an address-match enable, a match-sense bit, a broadcast permit and a two-bit multicast policy.

The verdict is registered on the clock edge that takes in the sixth address byte. It then stays fixed, along with the address class, until the first byte of the next frame arrives. Bytes after the address and configuration changes made after the verdict do not alter it. A frame that ends before its sixth byte gets a drop verdict with the class "none". Downstream logic uses the verdict to commit or discard the frame it is buffering.

Top module: `rx_da_filter`

## Requirements
- R1: The first received byte of a frame is the most significant address byte and is compared with `cfg_station[47:40]`. The sixth byte is compared with `cfg_station[7:0]`. A unicast address matches only when all 48 bits are equal.
- R2: `verdict_valid` rises one clock edge after the sixth address byte is accepted (`in_valid`=1). It stays high with `verdict_accept` and `verdict_class` unchanged until a byte with `in_sof`=1 is accepted. That byte clears `verdict_valid`.
- R3: An all-ones address gets class 3 (broadcast). It is accepted exactly when `cfg_bcast_ok`=1, whatever the multicast policy or match settings.
- R4: An address that is not all-ones and has bit 0 of its first byte set gets class 2 (multicast). It is accepted only when `cfg_mcast_mode`=2. Policy values 0, 1 and 3 drop it, and the match settings have no effect.
- R5: A unicast address (class 1) is accepted whenever `cfg_match_en`=0.
- R6: With `cfg_match_en`=1 and `cfg_match_sense`=1, a unicast address is accepted only if it matches the station address.
- R7: With `cfg_match_en`=1 and `cfg_match_sense`=0, a unicast address is accepted only if it does not match the station address.
- R8: A frame whose `in_eof` byte arrives as byte 1 to 5 gives `verdict_valid`=1, `verdict_accept`=0 and `verdict_class`=0 (none) one edge after that byte.
- R9: Bytes after the sixth, and configuration changes after the verdict, leave the verdict and class unchanged.
- R10: Cycles with `in_valid`=0 add no byte to the address. An `in_sof` byte in the middle of a frame restarts address capture from that byte.
- R11: After reset, `verdict_valid`, `verdict_accept` and `verdict_class` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on `in_data` this cycle |
| in_sof | input | 1 | The current byte is the first of a frame |
| in_eof | input | 1 | The current byte is the last of a frame |
| in_data | input | 8 | Received byte |
| cfg_station | input | 48 | Station address, first wire byte in bits 47:40 |
| cfg_match_en | input | 1 | Station address takes part in the unicast decision |
| cfg_match_sense | input | 1 | 1: accept matches only; 0: reject matches |
| cfg_bcast_ok | input | 1 | Accept all-ones address |
| cfg_mcast_mode | input | 2 | Multicast policy, 2 accepts, others drop |
| verdict_valid | output | 1 | Verdict for the current frame is available |
| verdict_accept | output | 1 | 1 keep frame, 0 drop frame |
| verdict_class | output | 2 | 0 none/short, 1 unicast, 2 multicast, 3 broadcast |

## Verification
A byte counter that slips, or a capture register that shifts on idle cycles, produces a verdict on the wrong edge. It also compares a skewed address, so the class or accept bit is wrong on the very next frame. A single byte lane that is wrongly compared shows only when a station address differs from the frame in that byte alone. Because of this, mismatches are swept one byte position at a time under both match senses. A verdict register that is not held shows as a changed accept bit in the trailing bytes of the same frame, or after a configuration change while the verdict is still valid.

// File: rtl/rx_da_pkg.sv
package rx_da_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_UNI   = 2'd1,
    CLS_MULTI = 2'd2,
    CLS_BCAST = 2'd3
  } da_class_e;

  localparam logic [1:0] MCAST_TAKE = 2'd2;
endpackage

// File: rtl/da_capture.sv
module da_capture #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 6,
  localparam int ADDR_W = BYTE_W * N_BYTES,
  localparam int CW     = $clog2(N_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BYTE_W-1:0] in_data,
  output logic [ADDR_W-1:0] addr_full,
  output logic              addr_done,
  output logic              short_end
);
  localparam logic [CW-1:0] FULL = CW'(N_BYTES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0]              cnt_q, cnt_d;
  logic [ADDR_W-BYTE_W-1:0]   shf_q, shf_d;
  logic                       cnt_en, shf_en;

  // next state
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (in_valid && in_sof) begin
      cnt_d  = ONE;
      cnt_en = 1'b1;
    end else if (in_valid && (cnt_q != FULL)) begin
      cnt_d  = cnt_q + ONE;
      cnt_en = 1'b1;
    end
  end

  always_comb begin
    shf_en = cnt_en;
    shf_d  = {shf_q[ADDR_W-2*BYTE_W-1:0], in_data};
  end

  assign addr_full = {shf_q, in_data};
  assign addr_done = cnt_en && (cnt_d == FULL);
  assign short_end = in_valid && in_eof && (cnt_d != FULL) &&
                     (in_sof || (cnt_q != FULL));

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q <= '0;
    end else if (shf_en) begin
      shf_q <= shf_d;
    end
  end
endmodule

// File: rtl/da_classify.sv
module da_classify
  import rx_da_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 6,
  localparam int ADDR_W = BYTE_W * N_BYTES
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] station,
  input  logic              match_en,
  input  logic              match_sense,
  input  logic              bcast_ok,
  input  logic [1:0]        mcast_mode,
  output da_class_e         cls,
  output logic              accept
);
  logic [N_BYTES-1:0] lane_eq;
  logic               hit, is_bcast, is_multi;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    assign lane_eq[g] = (addr[g*BYTE_W +: BYTE_W] == station[g*BYTE_W +: BYTE_W]);
  end

  assign hit      = &lane_eq;
  assign is_bcast = &addr;
  assign is_multi = addr[ADDR_W-BYTE_W];

  always_comb begin
    if (is_bcast) begin
      cls    = CLS_BCAST;
      accept = bcast_ok;
    end else if (is_multi) begin
      cls    = CLS_MULTI;
      accept = (mcast_mode == MCAST_TAKE);
    end else begin
      cls = CLS_UNI;
      if (!match_en) accept = 1'b1;
      else           accept = (hit == match_sense);
    end
  end
endmodule

// File: rtl/da_verdict.sv
module da_verdict
  import rx_da_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sof_byte,
  input  logic      addr_done,
  input  logic      short_end,
  input  da_class_e cls_in,
  input  logic      acc_in,
  output logic      v_valid,
  output logic      v_accept,
  output da_class_e v_class
);
  logic      val_d, acc_d, upd;
  da_class_e cls_d;

  // next state
  always_comb begin
    val_d = v_valid;
    acc_d = v_accept;
    cls_d = v_class;
    upd   = 1'b0;
    if (addr_done) begin
      val_d = 1'b1;
      acc_d = acc_in;
      cls_d = cls_in;
      upd   = 1'b1;
    end else if (short_end) begin
      val_d = 1'b1;
      acc_d = 1'b0;
      cls_d = CLS_NONE;
      upd   = 1'b1;
    end else if (sof_byte) begin
      val_d = 1'b0;
      acc_d = 1'b0;
      cls_d = CLS_NONE;
      upd   = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_valid  <= 1'b0;
      v_accept <= 1'b0;
      v_class  <= CLS_NONE;
    end else if (upd) begin
      v_valid  <= val_d;
      v_accept <= acc_d;
      v_class  <= cls_d;
    end
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 6,
  localparam int ADDR_W = BYTE_W * N_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [ADDR_W-1:0] cfg_station,
  input  logic              cfg_match_en,
  input  logic              cfg_match_sense,
  input  logic              cfg_bcast_ok,
  input  logic [1:0]        cfg_mcast_mode,
  output logic              verdict_valid,
  output logic              verdict_accept,
  output logic [1:0]        verdict_class
);
  logic [ADDR_W-1:0] addr_full;
  logic              addr_done, short_end, acc_c;
  da_class_e         cls_c, cls_q;

  da_capture #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .addr_full (addr_full),
    .addr_done (addr_done),
    .short_end (short_end)
  );

  da_classify #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_cls (
    .addr        (addr_full),
    .station     (cfg_station),
    .match_en    (cfg_match_en),
    .match_sense (cfg_match_sense),
    .bcast_ok    (cfg_bcast_ok),
    .mcast_mode  (cfg_mcast_mode),
    .cls         (cls_c),
    .accept      (acc_c)
  );

  da_verdict u_vrd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_byte  (in_valid && in_sof),
    .addr_done (addr_done),
    .short_end (short_end),
    .cls_in    (cls_c),
    .acc_in    (acc_c),
    .v_valid   (verdict_valid),
    .v_accept  (verdict_accept),
    .v_class   (cls_q)
  );

  assign verdict_class = cls_q;
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sof,
  input logic       in_eof,
  input logic       cfg_match_en,
  input logic       cfg_bcast_ok,
  input logic [1:0] cfg_mcast_mode,
  input logic       verdict_valid,
  input logic       verdict_accept,
  input logic [1:0] verdict_class
);
  // R2
  hold_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !(in_valid && in_sof)) |=>
      (verdict_valid && $stable(verdict_accept) && $stable(verdict_class)));

  // R2
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !in_eof) |=> !verdict_valid);

  // R8
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_class == 2'd0) |-> !verdict_accept);

  // R3
  bcast_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(verdict_valid) && verdict_class == 2'd3) |->
      (verdict_accept == $past(cfg_bcast_ok)));

  // R4
  mcast_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(verdict_valid) && verdict_class == 2'd2) |->
      (verdict_accept == ($past(cfg_mcast_mode) == 2'd2)));

  // R5
  unicast_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(verdict_valid) && verdict_class == 2'd1 && !$past(cfg_match_en)) |->
      verdict_accept);
endmodule

bind rx_da_filter rx_da_filter_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_sof         (in_sof),
  .in_eof         (in_eof),
  .cfg_match_en   (cfg_match_en),
  .cfg_bcast_ok   (cfg_bcast_ok),
  .cfg_mcast_mode (cfg_mcast_mode),
  .verdict_valid  (verdict_valid),
  .verdict_accept (verdict_accept),
  .verdict_class  (verdict_class)
);

// File: tb/sim_rx_da_filter.sv
module sim_rx_da_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic [47:0] cfg_station;
  logic        cfg_match_en, cfg_match_sense, cfg_bcast_ok;
  logic [1:0]  cfg_mcast_mode;
  logic        verdict_valid, verdict_accept;
  logic [1:0]  verdict_class;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;

  always #4 clk = ~clk;

  rx_da_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .cfg_station(cfg_station),
    .cfg_match_en(cfg_match_en), .cfg_match_sense(cfg_match_sense),
    .cfg_bcast_ok(cfg_bcast_ok), .cfg_mcast_mode(cfg_mcast_mode),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept),
    .verdict_class(verdict_class)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_byte(input logic [7:0] d, input logic s, input logic e);
    in_valid = 1'b1; in_sof = s; in_eof = e; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic idle();
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    @(negedge clk);
  endtask

  // total bytes n; eof on last; optional idle gap between bytes
  task automatic send(input logic [47:0] da, input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = (i < 6) ? da[47-8*i -: 8] : 8'(8'hA0 + i);
      drive_byte(b, i == 0, i == n - 1);
      if (gap && i != n - 1) idle();
    end
  endtask

  function automatic logic [2:0] model(input logic [47:0] da, input logic me,
                                        input logic se, input logic bc, input logic [1:0] mm);
    // {accept, class}
    if (da == '1)      return {bc, 2'd3};
    else if (da[40])   return {mm == 2'd2, 2'd2};
    else if (!me)      return {1'b1, 2'd1};
    else if (se)       return {da == STA, 2'd1};
    else               return {da != STA, 2'd1};
  endfunction

  task automatic expect_verdict(input string req, input logic [2:0] ex);
    chk({req, " valid"}, 8'(verdict_valid), 8'd1);
    chk({req, " accept"}, 8'(verdict_accept), 8'(ex[2]));
    chk({req, " class"}, 8'(verdict_class), 8'(ex[1:0]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] kinds [5];
    rst_n = 1'b0;
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
    cfg_station = STA; cfg_match_en = 0; cfg_match_sense = 0;
    cfg_bcast_ok = 0; cfg_mcast_mode = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", 8'(verdict_valid), 8'd0);
    chk("R11 accept", 8'(verdict_accept), 8'd0);
    chk("R11 class", 8'(verdict_class), 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    kinds[0] = STA;                      // unicast match
    kinds[1] = 48'h02_11_22_33_44_56;    // unicast mismatch
    kinds[2] = 48'h01_00_5E_00_00_01;    // multicast
    kinds[3] = 48'hFF_FF_FF_FF_FF_FE;    // multicast, near broadcast
    kinds[4] = '1;                       // broadcast

    // R1 R3 R4 R5 R6 R7 R10: sweep all configurations and address kinds
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 5; k++) begin
        cfg_match_en = c[0]; cfg_match_sense = c[1];
        cfg_bcast_ok = c[2]; cfg_mcast_mode = c[4:3];
        send(kinds[k], 8, c[0] ^ k[0]);
        expect_verdict("R3/R4/R5/R6/R7 sweep",
                       model(kinds[k], c[0], c[1], c[2], 2'(c[4:3])));
        idle();
      end
    end

    // R1 R6 R7: single-byte mismatch at each lane
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < 6; b++) begin
        logic [47:0] da;
        da = STA ^ (48'h40 << (8 * (5 - b)));
        cfg_match_en = 1; cfg_match_sense = s[0]; cfg_mcast_mode = 0; cfg_bcast_ok = 0;
        send(da, 6, 0);
        expect_verdict(s ? "R1 R6 lane" : "R1 R7 lane", {~s[0], 2'd1});
        idle();
      end
    end

    // R8 short frames of 1..5 bytes
    cfg_match_en = 0; cfg_bcast_ok = 1; cfg_mcast_mode = 2;
    for (int n = 1; n < 6; n++) begin
      send(STA, 8, 0);
      chk("R8 pre accept", 8'(verdict_accept), 8'd1);
      send(STA, n, 0);
      expect_verdict("R8 short", 3'b000);
      idle();
    end

    // R9 trailing bytes and config changes after verdict
    cfg_match_en = 0; cfg_match_sense = 1;
    send(kinds[1], 6, 0);
    expect_verdict("R9 base", 3'b101);
    cfg_match_en = 1;
    repeat (2) idle();
    drive_byte(8'hFF, 0, 0);
    drive_byte(8'h55, 0, 1);
    expect_verdict("R9 hold", 3'b101);

    // R2 sof clears verdict, verdict appears exactly after sixth byte
    for (int i = 0; i < 5; i++) begin
      drive_byte(STA[47-8*i -: 8], i == 0, 0);
      chk("R2 not yet", 8'(verdict_valid), 8'd0);
    end
    drive_byte(STA[7:0], 0, 0);
    expect_verdict("R2 sixth", 3'b101);

    // R10 restart on sof mid-frame
    cfg_bcast_ok = 0;
    drive_byte(8'hFF, 1, 0);
    drive_byte(8'hFF, 0, 0);
    drive_byte(8'hFF, 0, 0);
    send(STA, 7, 1);
    expect_verdict("R10 restart", 3'b101);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule